// File: doc/BRIEF.md
# Branch and Call Target Generator

This block works out the next program counter for the control-transfer instructions of an 8-bit controller with a 16-bit program space. It accepts one instruction at a time on a valid/ready input. The instruction arrives as the current PC, the opcode byte, two operand bytes and its length, together with a taken flag from the condition logic and the accumulator, data pointer and stack pointer values. It then returns the next PC and the new stack pointer as a one-cycle result pulse. Jumps and non-branching instructions produce their result one cycle after acceptance.

A subroutine call also has to save its return address. For a call, the block first drives two byte writes toward stack memory on back-to-back cycles, low byte first, each at a freshly pre-incremented stack address. It drops its input ready while it does this. The call's result pulse follows the second write.

Back-pressure works only on the input side: the block holds `in_ready` low while a call's writes are in progress, and an instruction counts as accepted only on a rising edge where `in_valid` and `in_ready` are both high. The result pulse and the stack write strobe have no ready signal. The consumer must take them in the cycle they appear. Deciding whether a condition holds, and the memory itself, are left to the surrounding logic.

Top module: `bt_target_gen`

## Requirements
- R1: After reset `out_valid`, `stk_we` and `busy` are 0 and `in_ready` is 1.
- R2: `in_ready` equals the inverse of `busy`. An accepted instruction that is not a call raises `out_valid` for exactly one cycle, in the cycle after acceptance, and the block can accept again in that same cycle.
- R3: Let the base be PC + length. An opcode whose low five bits are 00001 (short jump) or 10001 (short call) targets {base[15:11], opcode[7:5], operand1}, so the target stays inside the 2 KB page of the base.
- R4: Opcode 0x02 (long jump) and opcode 0x12 (long call) target {operand1, operand2}, with operand1 as the high byte.
- R5: Opcode 0x73 (indirect jump) targets DPTR + the zero-extended accumulator.
- R6: Opcode 0x80 is always taken. Any other opcode not named in R3 to R5 is taken when `cond_ok` is 1. A taken instruction targets base + the sign-extended displacement, where the displacement is operand2 when the length is 3 and operand1 otherwise.
- R7: A relative-class instruction that is not taken gives next PC = base.
- R8: All PC sums wrap modulo 65536.
- R9: A call writes to the stack on two consecutive cycles starting the cycle after acceptance: first address SP+1 with data base[7:0], then address SP+2 with data base[15:8]. The stack addresses wrap modulo 256.
- R10: A call's `out_valid` comes in the cycle after its second write, with `sp_next` = SP+2 mod 256. A non-call gives `sp_next` = SP.
- R11: `busy` is 1 and `in_ready` is 0 during both write cycles of a call, and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Block can accept an instruction |
| pc_cur | input | 16 | Address of the instruction's first byte |
| opcode | input | 8 | Opcode byte |
| opnd1 | input | 8 | First operand byte |
| opnd2 | input | 8 | Second operand byte |
| ins_len | input | 2 | Instruction length in bytes (1 to 3) |
| cond_ok | input | 1 | Branch condition holds |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| sp_cur | input | 8 | Stack pointer value |
| out_valid | output | 1 | One-cycle result pulse |
| pc_next | output | 16 | Next program counter |
| sp_next | output | 8 | New stack pointer |
| stk_we | output | 1 | Stack byte write strobe |
| stk_addr | output | 8 | Stack write address |
| stk_data | output | 8 | Stack write data |
| busy | output | 1 | Call push in progress |

## Verification
Two events can fall in the same cycle: the result pulse that ends a call, and the acceptance of the next instruction once `in_ready` comes back. The bench presents its next instruction in exactly that cycle after every call. It then checks that the call's target and stack pointer are still shown correctly, and that the new instruction's result follows on the next cycle. Runs of non-call instructions are also sent back to back, so that every result pulse overlaps with a new acceptance.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [2:0] {
    K_REL   = 3'd0,
    K_SJMP  = 3'd1,
    K_AJMP  = 3'd2,
    K_ACALL = 3'd3,
    K_LJMP  = 3'd4,
    K_LCALL = 3'd5,
    K_IND   = 3'd6
  } kind_e;

  localparam logic [4:0] SHORT_JMP_LO  = 5'b00001;
  localparam logic [4:0] SHORT_CALL_LO = 5'b10001;
  localparam logic [7:0] OP_LONG_JMP   = 8'h02;
  localparam logic [7:0] OP_LONG_CALL  = 8'h12;
  localparam logic [7:0] OP_IND_JMP    = 8'h73;
  localparam logic [7:0] OP_SHORT_REL  = 8'h80;
endpackage

// File: rtl/bt_decode.sv
module bt_decode
  import bt_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic       cond_ok,
  output kind_e      kind,
  output logic       is_call,
  output logic       taken
);
  always_comb begin
    if (opcode[4:0] == SHORT_JMP_LO)       kind = K_AJMP;
    else if (opcode[4:0] == SHORT_CALL_LO) kind = K_ACALL;
    else if (opcode == OP_LONG_JMP)        kind = K_LJMP;
    else if (opcode == OP_LONG_CALL)       kind = K_LCALL;
    else if (opcode == OP_IND_JMP)         kind = K_IND;
    else if (opcode == OP_SHORT_REL)       kind = K_SJMP;
    else                                   kind = K_REL;
  end

  assign is_call = (kind == K_ACALL) || (kind == K_LCALL);

  always_comb begin
    case (kind)
      K_REL:   taken = cond_ok;
      default: taken = 1'b1;
    endcase
  end
endmodule

// File: rtl/bt_target.sv
module bt_target
  import bt_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int D_W   = 8,
  parameter int LEN_W = 2
) (
  input  kind_e             kind,
  input  logic              taken,
  input  logic [PC_W-1:0]   pc_cur,
  input  logic [LEN_W-1:0]  ins_len,
  input  logic [D_W-1:0]    opcode,
  input  logic [D_W-1:0]    opnd1,
  input  logic [D_W-1:0]    opnd2,
  input  logic [D_W-1:0]    acc,
  input  logic [PC_W-1:0]   dptr,
  output logic [PC_W-1:0]   base,
  output logic [PC_W-1:0]   target
);
  localparam int LOW_W = D_W + 3;
  localparam int EXT_W = PC_W - D_W;

  logic [D_W-1:0]  disp;
  logic [PC_W-1:0] rel_t, abs_t, long_t, ind_t;

  assign base   = pc_cur + PC_W'(ins_len);
  assign disp   = (ins_len == LEN_W'(3)) ? opnd2 : opnd1;
  assign rel_t  = base + {{EXT_W{disp[D_W-1]}}, disp};
  assign abs_t  = {base[PC_W-1:LOW_W], opcode[D_W-1:D_W-3], opnd1};
  assign long_t = {opnd1, opnd2};
  assign ind_t  = dptr + {{EXT_W{1'b0}}, acc};

  always_comb begin
    case (kind)
      K_AJMP, K_ACALL: target = abs_t;
      K_LJMP, K_LCALL: target = long_t;
      K_IND:           target = ind_t;
      default:         target = taken ? rel_t : base;
    endcase
  end
endmodule

// File: rtl/bt_push_seq.sv
module bt_push_seq #(
  parameter int PC_W = 16,
  parameter int D_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_call,
  input  logic [PC_W-1:0]  target,
  input  logic [PC_W-1:0]  ret_addr,
  input  logic [D_W-1:0]   sp_cur,
  output logic             busy,
  output logic             out_valid,
  output logic [PC_W-1:0]  pc_next,
  output logic [D_W-1:0]   sp_next,
  output logic             stk_we,
  output logic [D_W-1:0]   stk_addr,
  output logic [D_W-1:0]   stk_data
);
  localparam int NB    = PC_W / D_W;
  localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;

  logic             pushing;
  logic [IDX_W-1:0] idx;
  logic [PC_W-1:0]  ret_q, tgt_q;
  logic [D_W-1:0]   sp_q;
  logic [D_W-1:0]   lane [NB];

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane[g] = ret_q[g*D_W +: D_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pushing   <= 1'b0;
      idx       <= '0;
      ret_q     <= '0;
      tgt_q     <= '0;
      sp_q      <= '0;
      out_valid <= 1'b0;
      pc_next   <= '0;
      sp_next   <= '0;
    end else begin
      out_valid <= 1'b0;
      if (!pushing) begin
        if (start) begin
          if (start_call) begin
            pushing <= 1'b1;
            idx     <= '0;
            ret_q   <= ret_addr;
            tgt_q   <= target;
            sp_q    <= sp_cur;
          end else begin
            out_valid <= 1'b1;
            pc_next   <= target;
            sp_next   <= sp_cur;
          end
        end
      end else if (idx == IDX_W'(NB - 1)) begin
        pushing   <= 1'b0;
        idx       <= '0;
        out_valid <= 1'b1;
        pc_next   <= tgt_q;
        sp_next   <= sp_q + D_W'(NB);
      end else begin
        idx <= idx + IDX_W'(1);
      end
    end
  end

  assign busy     = pushing;
  assign stk_we   = pushing;
  assign stk_addr = sp_q + D_W'(idx) + D_W'(1);
  assign stk_data = lane[idx];
endmodule

// File: rtl/bt_target_gen.sv
module bt_target_gen
  import bt_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int D_W   = 8,
  parameter int LEN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PC_W-1:0]  pc_cur,
  input  logic [D_W-1:0]   opcode,
  input  logic [D_W-1:0]   opnd1,
  input  logic [D_W-1:0]   opnd2,
  input  logic [LEN_W-1:0] ins_len,
  input  logic             cond_ok,
  input  logic [D_W-1:0]   acc,
  input  logic [PC_W-1:0]  dptr,
  input  logic [D_W-1:0]   sp_cur,
  output logic             out_valid,
  output logic [PC_W-1:0]  pc_next,
  output logic [D_W-1:0]   sp_next,
  output logic             stk_we,
  output logic [D_W-1:0]   stk_addr,
  output logic [D_W-1:0]   stk_data,
  output logic             busy
);
  kind_e           kind;
  logic            is_call, taken, accept;
  logic [PC_W-1:0] base, target;

  bt_decode u_dec (
    .opcode (opcode),
    .cond_ok(cond_ok),
    .kind   (kind),
    .is_call(is_call),
    .taken  (taken)
  );

  bt_target #(.PC_W(PC_W), .D_W(D_W), .LEN_W(LEN_W)) u_tgt (
    .kind   (kind),
    .taken  (taken),
    .pc_cur (pc_cur),
    .ins_len(ins_len),
    .opcode (opcode),
    .opnd1  (opnd1),
    .opnd2  (opnd2),
    .acc    (acc),
    .dptr   (dptr),
    .base   (base),
    .target (target)
  );

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  bt_push_seq #(.PC_W(PC_W), .D_W(D_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .start_call(is_call),
    .target    (target),
    .ret_addr  (base),
    .sp_cur    (sp_cur),
    .busy      (busy),
    .out_valid (out_valid),
    .pc_next   (pc_next),
    .sp_next   (sp_next),
    .stk_we    (stk_we),
    .stk_addr  (stk_addr),
    .stk_data  (stk_data)
  );
endmodule

// File: rtl/bt_target_gen_chk.sv
module bt_target_gen_chk #(
  parameter int PC_W  = 16,
  parameter int D_W   = 8,
  parameter int LEN_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [D_W-1:0]   opcode,
  input logic [D_W-1:0]   opnd1,
  input logic [D_W-1:0]   opnd2,
  input logic             out_valid,
  input logic [PC_W-1:0]  pc_next,
  input logic             stk_we,
  input logic [D_W-1:0]   stk_addr,
  input logic             busy
);
  // R3
  short_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && opcode[4:0] == 5'b00001) |=>
      (out_valid && pc_next[7:0] == $past(opnd1) && pc_next[10:8] == $past(opcode[7:5])));

  // R4
  long_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && opcode == 8'h02) |=>
      (out_valid && pc_next == {$past(opnd1), $past(opnd2)}));

  // R9
  push_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stk_we) |=> (stk_we && (stk_addr - $past(stk_addr)) == 8'd1));

  // R9
  push_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_we && $past(stk_we)) |=> !stk_we);

  // R10
  call_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stk_we) |-> out_valid);

  // R11
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_we |-> (busy && !in_ready));
endmodule

bind bt_target_gen bt_target_gen_chk #(.PC_W(PC_W), .D_W(D_W), .LEN_W(LEN_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .opcode   (opcode),
  .opnd1    (opnd1),
  .opnd2    (opnd2),
  .out_valid(out_valid),
  .pc_next  (pc_next),
  .stk_we   (stk_we),
  .stk_addr (stk_addr),
  .busy     (busy)
);

// File: tb/bt_target_gen_tb_top.sv
`timescale 1ns/1ps
module bt_target_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] pc_cur = '0;
  logic [7:0]  opcode = '0, opnd1 = '0, opnd2 = '0;
  logic [1:0]  ins_len = 2'd1;
  logic        cond_ok = 1'b0;
  logic [7:0]  acc = '0;
  logic [15:0] dptr = '0;
  logic [7:0]  sp_cur = '0;
  logic        out_valid;
  logic [15:0] pc_next;
  logic [7:0]  sp_next;
  logic        stk_we;
  logic [7:0]  stk_addr, stk_data;
  logic        busy;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bt_target_gen dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .pc_cur(pc_cur), .opcode(opcode), .opnd1(opnd1), .opnd2(opnd2),
    .ins_len(ins_len), .cond_ok(cond_ok), .acc(acc), .dptr(dptr),
    .sp_cur(sp_cur), .out_valid(out_valid), .pc_next(pc_next),
    .sp_next(sp_next), .stk_we(stk_we), .stk_addr(stk_addr),
    .stk_data(stk_data), .busy(busy)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit call_op(logic [7:0] op);
    return (op[4:0] == 5'b10001) || (op == 8'h12);
  endfunction

  function automatic logic [15:0] model_pc(logic [15:0] pc, logic [7:0] op,
      logic [7:0] b1, logic [7:0] b2, logic [1:0] len, logic c,
      logic [7:0] a, logic [15:0] dp);
    logic [15:0] bs;
    logic [7:0]  d;
    bs = pc + 16'(len);
    d  = (len == 2'd3) ? b2 : b1;
    if (op[4:0] == 5'b00001 || op[4:0] == 5'b10001) return {bs[15:11], op[7:5], b1};
    if (op == 8'h02 || op == 8'h12) return {b1, b2};
    if (op == 8'h73) return dp + {8'h00, a};
    if (op == 8'h80 || c) return bs + {{8{d[7]}}, d};
    return bs;
  endfunction

  // Drives at a falling edge; returns at the falling edge where the result shows.
  task automatic issue(logic [15:0] pc, logic [7:0] op, logic [7:0] b1, logic [7:0] b2,
      logic [1:0] len, logic c, logic [7:0] a, logic [15:0] dp, logic [7:0] sp, string tag);
    logic [15:0] ep, ret;
    ep  = model_pc(pc, op, b1, b2, len, c, a, dp);
    ret = pc + 16'(len);
    pc_cur = pc; opcode = op; opnd1 = b1; opnd2 = b2; ins_len = len;
    cond_ok = c; acc = a; dptr = dp; sp_cur = sp; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (call_op(op)) begin
      chk({"R9 first write ", tag}, {7'd0, stk_we, stk_addr}, {7'd0, 1'b1, 8'(sp + 8'd1)});
      chk({"R9 first data ", tag}, {8'd0, stk_data}, {8'd0, ret[7:0]});
      chk({"R11 busy first ", tag}, {14'd0, busy, in_ready}, 16'd2);
      @(negedge clk);
      chk({"R9 second write ", tag}, {7'd0, stk_we, stk_addr}, {7'd0, 1'b1, 8'(sp + 8'd2)});
      chk({"R9 second data ", tag}, {8'd0, stk_data}, {8'd0, ret[15:8]});
      chk({"R11 busy second ", tag}, {14'd0, busy, in_ready}, 16'd2);
      @(negedge clk);
      chk({"R10 call done ", tag}, {14'd0, out_valid, stk_we}, 16'd2);
      chk({"R10 call sp ", tag}, {8'd0, sp_next}, {8'd0, 8'(sp + 8'd2)});
      chk({"R11 ready back ", tag}, {15'd0, in_ready}, 16'd1);
    end else begin
      chk({"R2 result pulse ", tag}, {14'd0, out_valid, in_ready}, 16'd3);
      chk({"R10 sp kept ", tag}, {8'd0, sp_next}, {8'd0, sp});
    end
    chk({"R3-R8 next pc ", tag}, pc_next, ep);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0123));
    repeat (3) @(negedge clk);
    // R1
    chk("R1 out_valid", {15'd0, out_valid}, 16'd0);
    chk("R1 stk_we", {15'd0, stk_we}, 16'd0);
    chk("R1 busy/in_ready", {14'd0, busy, in_ready}, 16'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 R10 R3: short call 0x0123 -> 0x0345, SP 0x07
    issue(16'h0123, 8'h71, 8'h45, 8'h00, 2'd2, 1'b0, 8'h00, 16'h0000, 8'h07, "short call");
    chk("R3 short call target", pc_next, 16'h0345);
    // R3 page boundary: base crosses to next page
    issue(16'h07FE, 8'hE1, 8'h9A, 8'h00, 2'd2, 1'b0, 8'h00, 16'h0000, 8'h20, "page edge");
    chk("R3 page edge", pc_next, 16'h0F9A);
    // R4 long jump and long call with SP wrap (R9)
    issue(16'h1000, 8'h02, 8'hBE, 8'hEF, 2'd3, 1'b0, 8'h00, 16'h0000, 8'h10, "long jump");
    issue(16'hFFFE, 8'h12, 8'h12, 8'h34, 2'd3, 1'b0, 8'h00, 16'h0000, 8'hFF, "long call wrap");
    // R5 R8 indirect wrap
    issue(16'h4000, 8'h73, 8'h00, 8'h00, 2'd1, 1'b0, 8'h20, 16'hFFF0, 8'h30, "indirect");
    chk("R5 R8 indirect wrap", pc_next, 16'h0010);
    // R6 R8 relative forward wrap, backward extreme, 3-byte displacement select
    issue(16'hFFFE, 8'h80, 8'h05, 8'h00, 2'd2, 1'b0, 8'h00, 16'h0000, 8'h30, "rel wrap");
    chk("R6 R8 rel wrap", pc_next, 16'h0005);
    issue(16'h0100, 8'h40, 8'h80, 8'h00, 2'd2, 1'b1, 8'h00, 16'h0000, 8'h30, "rel -128");
    chk("R6 rel -128", pc_next, 16'h0082);
    issue(16'h0200, 8'hB4, 8'h11, 8'h7F, 2'd3, 1'b1, 8'h00, 16'h0000, 8'h30, "rel 3 byte");
    chk("R6 rel 3 byte", pc_next, 16'h0282);
    // R7 not taken
    issue(16'h0300, 8'h60, 8'h40, 8'h00, 2'd2, 1'b0, 8'h00, 16'h0000, 8'h30, "not taken");
    chk("R7 not taken", pc_next, 16'h0302);

    for (int i = 0; i < 400; i++) begin
      logic [7:0] op;
      logic [1:0] ln;
      op = 8'($urandom);
      case ($urandom % 6)
        0: op = {op[7:5], 5'b00001};
        1: op = {op[7:5], 5'b10001};
        2: op = 8'h12;
        3: op = 8'h73;
        default: ;
      endcase
      ln = 2'(1 + ($urandom % 3));
      issue(16'($urandom), op, 8'($urandom), 8'($urandom), ln, 1'($urandom),
            8'($urandom), 16'($urandom), 8'($urandom), "random");
    end

    @(negedge clk);
    chk("R2 idle after stream", {15'd0, out_valid}, 16'd0);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule